// File: doc/BRIEF.md
# Crosspoint switch control memory

This block holds the on/off state of every crosspoint in a matrix of 8 columns by 12 rows. A single write port (column address, row address, one data bit, chip select and strobe) reaches one crosspoint at a time. A master clear input turns every crosspoint off. The result is a flat 96-bit vector that drives the switch enables of the matrix.

All inputs are sampled on one system clock. While chip select and strobe are both high, the addressed cell follows the data input. On the clock where the registered strobe shows a falling edge, the data present in that cycle is committed and then held. Row codes form two banks of six rows, and each bank sits in an eight-code block. The two spare codes at the top of each block reach nothing, which lets several matrices share the address, data and strobe lines while their chip selects stay separate.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: After the synchronous system reset `rst`, all 96 outputs read 0.
- R2: `col_i` (3 bits) selects column 0..7 directly. `row_i` (4 bits, bit 0 least significant) selects a row as follows: codes 0..5 give rows 0..5, and codes 8..13 give rows 6..11. Crosspoint (column c, row r) appears at `sw_on_o[c*12 + r]`, so index 0 is column 0/row 0 and index 95 is column 7/row 11.
- R3: Row codes 6, 7, 14 and 15 address no crosspoint. A complete write to such a code leaves all 96 outputs unchanged.
- R4: When `cs_i` is low, strobe pulses leave all 96 outputs unchanged.
- R5: While `cs_i` and `strb_i` are high and `clr_i` is low, the addressed output equals the `din_i` sampled at the previous clock edge. It follows every change of the data.
- R6: On the clock where `strb_i` is low after having been high, the `din_i` of that same cycle is stored (with `cs_i` high). Once the strobe stays low, later changes of `din_i` do not alter the stored bit.
- R7: A write changes at most the one addressed output. All other outputs keep their state.
- R8: `clr_i` high clears all 96 outputs at the next clock edge, whatever the state of `cs_i`. It overrides a write that is in progress, including the strobe fall that occurs during the clear.
- R9: A stored data value of 1 turns the crosspoint on (output 1), and a value of 0 turns it off (output 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_i | input | 1 | Master clear, active high; turns all crosspoints off |
| cs_i | input | 1 | Chip select, active high |
| strb_i | input | 1 | Write strobe, active high |
| din_i | input | 1 | Data bit: 1 on, 0 off |
| col_i | input | 3 | Column address |
| row_i | input | 4 | Row code (sparse) |
| sw_on_o | output | 96 | Crosspoint enables, index column*12 + row |

## Verification
The hardest case to reach is the last cycle of a strobe. There the strobe is already low, so the block must still accept a write, but only with the data and address of that cycle and only when no clear is pending. The stimulus drops the strobe and changes the data in the same cycle, then changes the data again with the strobe low. This separates a commit taken from the falling-edge cycle from one taken a cycle early or a cycle late. A second sequence keeps the clear asserted across the strobe fall, so that an override which blocks only the transparent phase would show up.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Default geometry of the crosspoint matrix
    localparam int XPT_COLS  = 8;
    localparam int XPT_ROWS  = 12;
    localparam int XPT_CBITS = $clog2(XPT_COLS);
    localparam int XPT_RBITS = 4;

    // Phase of the write strobe as seen in the clock domain
    typedef enum logic [1:0] {
        STB_IDLE  = 2'd0,
        STB_OPEN  = 2'd1,
        STB_CLOSE = 2'd2
    } stb_phase_e;

    // Write event delivered to the cell bank
    typedef struct packed {
        logic wr;      // addressed cell loads data this cycle
        logic commit;  // this cycle is the strobe's falling edge
    } stb_ev_t;

endpackage

// File: rtl/xpt_strobe_track.sv
module xpt_strobe_track
    import xpt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    cs,
    input  logic    strb,
    output stb_ev_t ev
);

    logic       strb_q;
    stb_phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) strb_q <= 1'b0;
        else     strb_q <= strb;
    end

    always_comb begin
        if (strb)        phase = STB_OPEN;
        else if (strb_q) phase = STB_CLOSE;
        else             phase = STB_IDLE;
    end

    always_comb begin
        ev.commit = (phase == STB_CLOSE);
        ev.wr     = cs && !clr && (phase != STB_IDLE);
    end

    // A falling edge cannot repeat on consecutive cycles
    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ev.commit |=> !ev.commit); // R6

endmodule

// File: rtl/xpt_addr_dec.sv
module xpt_addr_dec #(
    parameter int COLS  = 8,
    parameter int ROWS  = 12,
    parameter int CBITS = 3,
    parameter int RBITS = 4,
    localparam int N    = COLS * ROWS,
    localparam int HALF = ROWS / 2,
    localparam int IW   = $clog2(N)
) (
    input  logic [CBITS-1:0] col,
    input  logic [RBITS-1:0] rcode,
    output logic [N-1:0]     sel
);

    logic             bank;
    logic [RBITS-2:0] off;
    logic             hit;
    int               idx_i;
    logic [IW-1:0]    idx;

    always_comb begin
        bank  = rcode[RBITS-1];
        off   = rcode[RBITS-2:0];
        hit   = (int'(off) < HALF);
        idx_i = int'(col) * ROWS + (bank ? HALF : 0) + int'(off);
        idx   = IW'(idx_i);
        sel   = '0;
        if (hit) sel[idx] = 1'b1;
    end

endmodule

// File: rtl/xpt_cell_bank.sv
module xpt_cell_bank #(
    parameter int N = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr,
    input  logic         din,
    input  logic [N-1:0] sel,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk) begin
            if (rst || clr)       cell_q <= 1'b0;
            else if (wr && sel[i]) cell_q <= din;
        end
        assign q[i] = cell_q;
    end

endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem
    import xpt_pkg::*;
#(
    parameter int COLS  = XPT_COLS,
    parameter int ROWS  = XPT_ROWS,
    parameter int CBITS = XPT_CBITS,
    parameter int RBITS = XPT_RBITS,
    localparam int N    = COLS * ROWS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             cs_i,
    input  logic             strb_i,
    input  logic             din_i,
    input  logic [CBITS-1:0] col_i,
    input  logic [RBITS-1:0] row_i,
    output logic [N-1:0]     sw_on_o
);

    stb_ev_t      ev;
    logic [N-1:0] sel;

    xpt_strobe_track u_strb (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_i),
        .cs   (cs_i),
        .strb (strb_i),
        .ev   (ev)
    );

    xpt_addr_dec #(
        .COLS  (COLS),
        .ROWS  (ROWS),
        .CBITS (CBITS),
        .RBITS (RBITS)
    ) u_dec (
        .col   (col_i),
        .rcode (row_i),
        .sel   (sel)
    );

    xpt_cell_bank #(
        .N (N)
    ) u_bank (
        .clk (clk),
        .rst (rst),
        .clr (clr_i),
        .wr  (ev.wr),
        .din (din_i),
        .sel (sel),
        .q   (sw_on_o)
    );

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (sw_on_o == '0)); // R8

    AST_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cs_i && !clr_i) |=> $stable(sw_on_o)); // R4

    AST_HOLE_KEEP: assert property (@(posedge clk) disable iff (rst)
        ((sel == '0) && !clr_i) |=> $stable(sw_on_o)); // R3

    AST_ONE_CELL: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ($countones(sw_on_o ^ $past(sw_on_o)) <= 1)); // R7

    AST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (cs_i && strb_i && !clr_i && (sel != '0))
        |=> ((sw_on_o & $past(sel)) == ($past(din_i) ? $past(sel) : '0))); // R5

endmodule

// File: tb/tb_xpt_ctrl_mem.sv
module tb_xpt_ctrl_mem;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        cs_i = 1'b0;
    logic        strb_i = 1'b0;
    logic        din_i = 1'b0;
    logic [2:0]  col_i = '0;
    logic [3:0]  row_i = '0;
    logic [95:0] sw_on_o;

    logic [95:0] exp_v = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xpt_ctrl_mem dut (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr_i),
        .cs_i    (cs_i),
        .strb_i  (strb_i),
        .din_i   (din_i),
        .col_i   (col_i),
        .row_i   (row_i),
        .sw_on_o (sw_on_o)
    );

    // Index from the mapping rule; -1 for a spare row code
    function automatic int map_idx(int c, int code);
        if (code < 6)                 return c * 12 + code;
        if (code >= 8 && code < 14)   return c * 12 + code - 2;
        return -1;
    endfunction

    task automatic check(string tag, logic [95:0] expv);
        n_chk++;
        if (sw_on_o !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, sw_on_o, expv);
        end
    endtask

    task automatic full_write(int c, int code, logic d);
        int k;
        @(negedge clk);
        cs_i = 1'b1; col_i = 3'(c); row_i = 4'(code); din_i = d; strb_i = 1'b1;
        @(negedge clk);
        strb_i = 1'b0;
        @(negedge clk);
        cs_i = 1'b0;
        k = map_idx(c, code);
        if (k >= 0) exp_v[k] = d;
    endtask

    task automatic t_reset();
        check("R1 reset clears all", 96'b0);
    endtask

    task automatic t_map();
        full_write(0, 0, 1'b1);  check("R2 R9 col0 row0 -> idx0", exp_v);
        full_write(7, 13, 1'b1); check("R2 col7 code13 -> idx95", exp_v);
        full_write(3, 5, 1'b1);  check("R2 col3 code5 -> idx41", exp_v);
        full_write(2, 8, 1'b1);  check("R2 col2 code8 -> idx30", exp_v);
        if (!sw_on_o[95] || !sw_on_o[30]) begin
            n_bad++; $display("FAIL R2: idx95=%b idx30=%b expected 1 1", sw_on_o[95], sw_on_o[30]);
        end
        n_chk++;
    endtask

    task automatic t_holes();
        full_write(1, 6, 1'b1);  check("R3 code6 no effect", exp_v);
        full_write(4, 7, 1'b1);  check("R3 code7 no effect", exp_v);
        full_write(5, 14, 1'b1); check("R3 code14 no effect", exp_v);
        full_write(6, 15, 1'b1); check("R3 code15 no effect", exp_v);
    endtask

    task automatic t_cs_low();
        @(negedge clk);
        cs_i = 1'b0; col_i = 3'd4; row_i = 4'd2; din_i = 1'b1; strb_i = 1'b1;
        @(negedge clk);
        strb_i = 1'b0;
        @(negedge clk);
        check("R4 cs low strobe ignored", exp_v);
    endtask

    task automatic t_follow_commit();
        @(negedge clk);
        cs_i = 1'b1; col_i = 3'd1; row_i = 4'd2; din_i = 1'b1; strb_i = 1'b1;
        @(negedge clk);
        exp_v[14] = 1'b1; check("R5 follows data 1", exp_v);
        din_i = 1'b0;
        @(negedge clk);
        exp_v[14] = 1'b0; check("R5 follows data 0", exp_v);
        din_i = 1'b1;
        @(negedge clk);
        exp_v[14] = 1'b1; check("R5 follows data 1 again", exp_v);
        strb_i = 1'b0; din_i = 1'b0;
        @(negedge clk);
        exp_v[14] = 1'b0; check("R6 fall-cycle data committed", exp_v);
        din_i = 1'b1;
        @(negedge clk);
        check("R6 held after fall", exp_v);
        cs_i = 1'b0;
    endtask

    task automatic t_off();
        full_write(0, 0, 1'b0);
        check("R9 R7 write 0 turns off only idx0", exp_v);
    endtask

    task automatic t_clear();
        full_write(5, 9, 1'b1);
        check("R7 setup before clear", exp_v);
        @(negedge clk);
        cs_i = 1'b0; clr_i = 1'b1;
        @(negedge clk);
        exp_v = '0; check("R8 clear with cs low", exp_v);
        clr_i = 1'b0;
        full_write(6, 3, 1'b1);
        check("R8 setup before override", exp_v);
        @(negedge clk);
        cs_i = 1'b1; col_i = 3'd2; row_i = 4'd1; din_i = 1'b1; strb_i = 1'b1; clr_i = 1'b1;
        @(negedge clk);
        exp_v = '0; check("R8 clear overrides open strobe", exp_v);
        strb_i = 1'b0;
        @(negedge clk);
        clr_i = 1'b0; cs_i = 1'b0;
        @(negedge clk);
        check("R8 clear blocks strobe fall", exp_v);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_holes();
        t_cs_low();
        t_follow_commit();
        t_off();
        t_clear();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule